// File: doc/BRIEF.md
# Gated Serial Transmitter with Line Control

This block turns bytes written by a host into an asynchronous serial bit stream. Accepted bytes wait in a 16-entry holding queue. A shift engine takes them one at a time and sends each one as a frame: a low start bit, 5 to 8 data bits with the least significant bit first, an optional parity bit, and 1, 1.5 or 2 high stop bits. Every bit lasts a fixed number of baud ticks, and the baud ticks come from an external 16x oversample enable.

Two controls act on the output at run time. A break control forces the line low at once. A transmit-enable gate lets the character on the line finish, then stops any further character leaving the queue until the gate opens again. This supports software flow control. Two status pins report the state of the path: one shows that the queue is empty, and one shows that the queue and the shift engine are both idle.

The host port uses a valid/ready handshake. A byte is taken on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` goes low while the queue holds 16 bytes. A byte offered while `wr_ready` is low is not taken, and the host is expected to hold it or drop it. A one-cycle pulse on `flush` empties the queue.

Top module: `gated_uart_tx`

## Requirements
- R1: Each frame starts with one low start bit. The data bits follow with the least significant bit first. `word_len` codes 0, 1, 2 and 3 send 5, 6, 7 and 8 data bits. Every start, data and parity bit lasts 16 baud ticks. The idle line is high.
- R2: When `par_en`=1, a parity bit follows the data bits. `par_sel`=0 gives odd parity over the data bits and the parity bit together. `par_sel`=1 gives even parity. `par_sel`=2 forces the parity bit to 1, and `par_sel`=3 forces it to 0. When `par_en`=0, no parity bit is sent.
- R3: The stop interval lasts 16 ticks when `two_stop`=0. When `two_stop`=1 it lasts 32 ticks, or 24 ticks when `word_len`=0.
- R4: While `brk` is 1, `txd` is 0 in the same cycle, whatever the engine is doing.
- R5: While `tx_en` is 0, no byte moves from the queue into the shift engine. A frame already on the line completes. `tx_en` is meant to be held at 1 after reset.
- R6: `hold_empty` is 1 whenever the queue holds no byte, including after reset. It is 0 from the cycle after a byte is accepted.
- R7: `tx_empty` is 1 only when the queue is empty and the shift engine is idle. It is 1 after reset and returns to 1 once the last stop interval ends.
- R8: With 16 bytes queued, `wr_ready` is 0. A byte offered in that state is neither stored nor sent.
- R9: A `flush` pulse empties the queue by the next cycle. A write offered in the same cycle as the pulse is discarded.
- R10: The line settings are sampled when a byte enters the shift engine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | 16x oversample enable, one cycle wide |
| wr_valid | input | 1 | Host offers a byte |
| wr_ready | output | 1 | Queue can accept a byte |
| wr_data | input | 8 | Byte to send; bit 0 is sent first |
| flush | input | 1 | Pulse that empties the queue |
| word_len | input | 2 | Data bits minus 5 |
| two_stop | input | 1 | Longer stop interval |
| par_en | input | 1 | Append a parity bit |
| par_sel | input | 2 | Parity mode: odd, even, force 1, force 0 |
| brk | input | 1 | Force the line low |
| tx_en | input | 1 | Allow new bytes to start |
| txd | output | 1 | Serial output |
| hold_empty | output | 1 | Queue holds no byte |
| tx_empty | output | 1 | Queue and shift engine both idle |

## Verification
Two of the block's functions can fall in the same cycle: a host write and a `flush` pulse. The bench first queues bytes while `tx_en` is 0. It then raises `flush` and `wr_valid` together on a single edge. The result is judged at the ports. `hold_empty` and `tx_empty` must read 1 on the next cycle. After the gate opens, the line must stay high for several frame times, which shows that neither the old bytes nor the concurrent byte survived.

A second overlap is the gate closing while a frame is on the line. That frame must arrive intact, and the byte queued behind it must wait until the gate opens again.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int DATA_W   = 8;
  localparam int MIN_BITS = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  typedef struct packed {
    logic [1:0] wlen;
    logic       two_stop;
    logic       par_en;
    logic [1:0] par_mode;
  } line_cfg_t;

  // Parity bit for the active data bits under the selected mode
  function automatic logic calc_parity(logic [DATA_W-1:0] d, logic [1:0] wlen,
                                       logic [1:0] mode);
    logic [DATA_W-1:0] mask;
    logic              ones;
    mask = {DATA_W{1'b1}} >> (DATA_W - MIN_BITS - int'(wlen));
    ones = ^(d & mask);
    case (mode)
      2'b00:   return ~ones;
      2'b01:   return ones;
      2'b10:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/txq_fifo.sv
module txq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [W-1:0]    mem [DEPTH];
  logic [AW-1:0]   wptr, rptr;
  logic [CNTW-1:0] count;
  logic            push_ok, pop_ok;

  function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CNTW'(DEPTH));
  assign push_ok = push && !full && !clear;
  assign pop_ok  = pop && !empty && !clear;
  assign dout    = mem[rptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (clear) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= nxt(wptr);
      if (pop_ok)  rptr <= nxt(rptr);
      count <= count + CNTW'(push_ok) - CNTW'(pop_ok);
    end
  end
endmodule

// File: rtl/tx_serializer.sv
module tx_serializer
  import uart_tx_pkg::*;
#(
  parameter int TPB = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  line_cfg_t         cfg,
  input  logic              avail,
  input  logic [DATA_W-1:0] din,
  output logic              take,
  output logic              busy,
  output logic              line_bit
);
  localparam int CW = $clog2(2 * TPB) + 1;
  localparam int IW = $clog2(DATA_W);

  tx_state_e         st;
  logic [CW-1:0]     cnt, stop_len_q, cur_len;
  logic [DATA_W-1:0] shreg;
  logic [IW-1:0]     idx, last_idx;
  logic              par_q, has_par_q, bit_end;
  logic [CW-1:0]     stop_len_d;

  assign take    = (st == ST_IDLE) && avail;
  assign busy    = (st != ST_IDLE);
  assign cur_len = (st == ST_STOP) ? stop_len_q : CW'(TPB);
  assign bit_end = tick && (cnt == cur_len - 1'b1);

  always_comb begin
    if (!cfg.two_stop)        stop_len_d = CW'(TPB);
    else if (cfg.wlen == 2'b00) stop_len_d = CW'(TPB + TPB / 2);
    else                      stop_len_d = CW'(2 * TPB);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      cnt        <= '0;
      shreg      <= '0;
      idx        <= '0;
      last_idx   <= '0;
      par_q      <= 1'b0;
      has_par_q  <= 1'b0;
      stop_len_q <= CW'(TPB);
    end else if (st == ST_IDLE) begin
      if (take) begin
        st         <= ST_START;
        cnt        <= '0;
        shreg      <= din;
        idx        <= '0;
        last_idx   <= IW'(cfg.wlen) + IW'(MIN_BITS - 1);
        par_q      <= calc_parity(din, cfg.wlen, cfg.par_mode);
        has_par_q  <= cfg.par_en;
        stop_len_q <= stop_len_d;
      end
    end else if (tick) begin
      if (bit_end) begin
        cnt <= '0;
        case (st)
          ST_START: st <= ST_DATA;
          ST_DATA: begin
            if (idx == last_idx) begin
              st <= has_par_q ? ST_PAR : ST_STOP;
            end else begin
              idx   <= idx + 1'b1;
              shreg <= shreg >> 1;
            end
          end
          ST_PAR:  st <= ST_STOP;
          default: st <= ST_IDLE;
        endcase
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_comb begin
    case (st)
      ST_START: line_bit = 1'b0;
      ST_DATA:  line_bit = shreg[0];
      ST_PAR:   line_bit = par_q;
      default:  line_bit = 1'b1;
    endcase
  end
endmodule

// File: rtl/gated_uart_tx.sv
module gated_uart_tx
  import uart_tx_pkg::*;
#(
  parameter int FIFO_DEPTH    = 16,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              flush,
  input  logic [1:0]        word_len,
  input  logic              two_stop,
  input  logic              par_en,
  input  logic [1:0]        par_sel,
  input  logic              brk,
  input  logic              tx_en,
  output logic              txd,
  output logic              hold_empty,
  output logic              tx_empty
);
  logic              q_empty, q_full, q_pop, ser_busy, line_bit;
  logic [DATA_W-1:0] q_dout;
  line_cfg_t         cfg;

  assign cfg = '{wlen: word_len, two_stop: two_stop, par_en: par_en, par_mode: par_sel};

  txq_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_q (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (flush),
    .push  (wr_valid),
    .din   (wr_data),
    .pop   (q_pop),
    .dout  (q_dout),
    .empty (q_empty),
    .full  (q_full)
  );

  tx_serializer #(.TPB(TICKS_PER_BIT)) u_ser (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (baud_tick),
    .cfg      (cfg),
    .avail    (!q_empty && tx_en),
    .din      (q_dout),
    .take     (q_pop),
    .busy     (ser_busy),
    .line_bit (line_bit)
  );

  assign wr_ready   = !q_full;
  assign hold_empty = q_empty;
  assign tx_empty   = q_empty && !ser_busy;
  assign txd        = brk ? 1'b0 : line_bit;
endmodule

// File: rtl/uart_tx_chk.sv
module uart_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_valid,
  input logic wr_ready,
  input logic flush,
  input logic brk,
  input logic tx_en,
  input logic txd,
  input logic hold_empty,
  input logic tx_empty,
  input logic ser_busy
);
  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty && !brk |-> txd);

  // R4
  brk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> !txd);

  // R5
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en && !ser_busy |=> !ser_busy);

  // R6
  write_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready && !flush |=> !hold_empty);

  // R7
  empty_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_empty) |-> ($fell(ser_busy) || $past(flush)));

  // R8
  full_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |-> !hold_empty);

  // R9
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> hold_empty);
endmodule

bind gated_uart_tx uart_tx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .flush      (flush),
  .brk        (brk),
  .tx_en      (tx_en),
  .txd        (txd),
  .hold_empty (hold_empty),
  .tx_empty   (tx_empty),
  .ser_busy   (ser_busy)
);

// File: tb/tb_gated_uart_tx.sv
`timescale 1ns/1ps
module tb_gated_uart_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [7:0] wr_data = 8'h00;
  logic       flush = 1'b0;
  logic [1:0] word_len = 2'd3;
  logic       two_stop = 1'b0;
  logic       par_en = 1'b0;
  logic [1:0] par_sel = 2'd0;
  logic       brk = 1'b0;
  logic       tx_en = 1'b1;
  logic       txd, hold_empty, tx_empty;

  int checks = 0, fails = 0;
  int tick_div = 1, tcnt = 0, bit_clks = 16;
  longint cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    tcnt <= (tcnt + 1 >= tick_div) ? 0 : tcnt + 1;
  end
  assign baud_tick = (tcnt == 0);

  gated_uart_tx dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .flush(flush), .word_len(word_len),
    .two_stop(two_stop), .par_en(par_en), .par_sel(par_sel), .brk(brk),
    .tx_en(tx_en), .txd(txd), .hold_empty(hold_empty), .tx_empty(tx_empty)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_par(input int d, input int n, input int mode);
    int ones = $countones(d & ((1 << n) - 1)) % 2;
    case (mode)
      0: return (ones == 0) ? 1 : 0;
      1: return ones;
      2: return 1;
      default: return 0;
    endcase
  endfunction

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic set_cfg(input int wl, input bit ts, input bit pe, input int ps);
    @(negedge clk);
    word_len = 2'(wl);
    two_stop = ts;
    par_en = pe;
    par_sel = 2'(ps);
  endtask

  task automatic recv(input int nb, input bit pe, output int data, output int parb,
                      output int stopb, output longint t0, output bit found);
    int w = 0;
    found = 0; data = 0; parb = -1; stopb = -1; t0 = 0;
    while (txd !== 1'b0 && w < 4000) begin
      @(negedge clk);
      w++;
    end
    if (txd !== 1'b0) return;
    found = 1;
    t0 = cyc;
    repeat (bit_clks / 2) @(negedge clk);
    check(txd == 1'b0, "R1", "start bit level", int'(txd), 0);
    for (int i = 0; i < nb; i++) begin
      repeat (bit_clks) @(negedge clk);
      data |= int'(txd) << i;
    end
    if (pe) begin
      repeat (bit_clks) @(negedge clk);
      parb = int'(txd);
    end
    repeat (bit_clks) @(negedge clk);
    stopb = int'(txd);
  endtask

  task automatic quiet_line(input int n, input string req, input string what);
    int lows = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (txd == 1'b0) lows++;
    end
    check(lows == 0, req, what, lows, 0);
  endtask

  task automatic frame_test(input int d, input int wl, input bit pe, input int ps,
                            input string req);
    int data, parb, stopb, nb;
    longint t0;
    bit found;
    nb = wl + 5;
    set_cfg(wl, 1'b0, pe, ps);
    wr(8'(d));
    recv(nb, pe, data, parb, stopb, t0, found);
    check(found, req, "frame appeared", int'(found), 1);
    check(data == (d & ((1 << nb) - 1)), "R1", "data bits", data, d & ((1 << nb) - 1));
    if (pe) check(parb == exp_par(d, nb, ps), "R2", "parity bit", parb, exp_par(d, nb, ps));
    check(stopb == 1, "R1", "stop level", stopb, 1);
    repeat (bit_clks) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(txd == 1'b1, "R1", "reset txd", int'(txd), 1);
    check(hold_empty == 1'b1, "R6", "reset hold_empty", int'(hold_empty), 1);
    check(tx_empty == 1'b1, "R7", "reset tx_empty", int'(tx_empty), 1);
    check(wr_ready == 1'b1, "R8", "reset wr_ready", int'(wr_ready), 1);
  endtask

  task automatic t_frames;
    frame_test(8'hA5, 3, 1'b0, 0, "R1");
    frame_test(8'h2C, 1, 1'b0, 0, "R1");
    frame_test(8'h13, 0, 1'b1, 1, "R2");
    frame_test(8'h41, 2, 1'b1, 0, "R2");
    frame_test(8'h00, 3, 1'b1, 2, "R2");
    frame_test(8'h3F, 1, 1'b1, 3, "R2");
  endtask

  task automatic t_tick_gap;
    @(negedge clk);
    tick_div = 3;
    bit_clks = 48;
    frame_test(8'h5A, 2, 1'b1, 1, "R1");
    @(negedge clk);
    tick_div = 1;
    bit_clks = 16;
  endtask

  task automatic gap_test(input int wl, input bit ts, input int ftick, input string req);
    int d0, p0, s0, d1, p1, s1;
    longint t0, t1;
    bit f0, f1;
    set_cfg(wl, ts, 1'b0, 0);
    wr(8'h55);
    wr(8'h0F);
    recv(wl + 5, 1'b0, d0, p0, s0, t0, f0);
    recv(wl + 5, 1'b0, d1, p1, s1, t1, f1);
    check(f0 && f1, req, "both frames seen", int'(f0 && f1), 1);
    check((t1 - t0 >= ftick) && (t1 - t0 <= ftick + 2), req, "frame spacing",
          int'(t1 - t0), ftick + 1);
    repeat (3 * bit_clks) @(negedge clk);
  endtask

  task automatic t_stops;
    gap_test(3, 1'b0, 160, "R3");
    gap_test(3, 1'b1, 176, "R3");
    gap_test(0, 1'b1, 120, "R3");
    set_cfg(3, 1'b0, 1'b0, 0);
  endtask

  task automatic t_break;
    @(negedge clk);
    brk = 1'b1;
    #1 check(txd == 1'b0, "R4", "break at idle", int'(txd), 0);
    repeat (5) @(negedge clk);
    check(txd == 1'b0, "R4", "break held", int'(txd), 0);
    brk = 1'b0;
    #1 check(txd == 1'b1, "R4", "break released", int'(txd), 1);
    wr(8'hFF);
    repeat (50) @(negedge clk);
    check(txd == 1'b1, "R1", "ones data bit", int'(txd), 1);
    brk = 1'b1;
    #1 check(txd == 1'b0, "R4", "break in frame", int'(txd), 0);
    @(negedge clk);
    brk = 1'b0;
    repeat (200) @(negedge clk);
    check(tx_empty == 1'b1 && txd == 1'b1, "R7", "idle after frame",
          int'(tx_empty && txd), 1);
  endtask

  task automatic t_status;
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data = 8'h81;
    @(negedge clk);
    wr_valid = 1'b0;
    check(hold_empty == 1'b0, "R6", "hold_empty after write", int'(hold_empty), 0);
    check(tx_empty == 1'b0, "R7", "tx_empty after write", int'(tx_empty), 0);
    @(negedge clk);
    check(hold_empty == 1'b1, "R6", "hold_empty after load", int'(hold_empty), 1);
    check(tx_empty == 1'b0, "R7", "tx_empty while shifting", int'(tx_empty), 0);
    repeat (170) @(negedge clk);
    check(tx_empty == 1'b1, "R7", "tx_empty after stop", int'(tx_empty), 1);
  endtask

  task automatic t_gate;
    int d, p, s;
    longint t;
    bit f;
    wr(8'hC3);
    wr(8'h3C);
    fork
      begin
        repeat (30) @(negedge clk);
        tx_en = 1'b0;
      end
      recv(8, 1'b0, d, p, s, t, f);
    join
    check(f && d == 8'hC3 && s == 1, "R5", "frame in flight completes", d, 8'hC3);
    quiet_line(300, "R5", "low samples while gated");
    check(hold_empty == 1'b0 && tx_empty == 1'b0, "R5", "byte still queued",
          int'(hold_empty), 0);
    @(negedge clk);
    tx_en = 1'b1;
    recv(8, 1'b0, d, p, s, t, f);
    check(f && d == 8'h3C, "R5", "queued byte after reopen", d, 8'h3C);
    repeat (bit_clks) @(negedge clk);
  endtask

  task automatic t_full;
    int d, p, s, bad;
    longint t;
    bit f;
    @(negedge clk);
    tx_en = 1'b0;
    for (int i = 0; i < 16; i++) wr(8'(8'h30 + i));
    check(wr_ready == 1'b0, "R8", "ready low when full", int'(wr_ready), 0);
    wr(8'hEE);
    @(negedge clk);
    tx_en = 1'b1;
    bad = 0;
    for (int i = 0; i < 16; i++) begin
      recv(8, 1'b0, d, p, s, t, f);
      if (!f || d != 8'h30 + i) bad++;
    end
    check(bad == 0, "R8", "sixteen queued bytes in order", bad, 0);
    quiet_line(400, "R8", "extra frame from dropped write");
    check(tx_empty == 1'b1, "R8", "drained", int'(tx_empty), 1);
  endtask

  task automatic t_flush;
    @(negedge clk);
    tx_en = 1'b0;
    wr(8'h11);
    wr(8'h22);
    @(negedge clk);
    flush = 1'b1;
    wr_valid = 1'b1;
    wr_data = 8'h77;
    @(negedge clk);
    flush = 1'b0;
    wr_valid = 1'b0;
    check(hold_empty == 1'b1, "R9", "hold_empty after flush", int'(hold_empty), 1);
    check(tx_empty == 1'b1, "R9", "tx_empty after flush", int'(tx_empty), 1);
    tx_en = 1'b1;
    quiet_line(400, "R9", "frames after flush");
  endtask

  task automatic t_cfg_latch;
    int d, p, s;
    longint t;
    bit f;
    set_cfg(3, 1'b0, 1'b0, 0);
    wr(8'h96);
    fork
      begin
        repeat (20) @(negedge clk);
        word_len = 2'd0;
        par_en = 1'b1;
      end
      recv(8, 1'b0, d, p, s, t, f);
    join
    check(f && d == 8'h96, "R10", "data with settings changed mid-frame", d, 8'h96);
    check(s == 1, "R10", "no parity inserted mid-frame", s, 1);
    repeat (bit_clks) @(negedge clk);
    set_cfg(3, 1'b0, 1'b0, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_frames();
    t_tick_gap();
    t_stops();
    t_break();
    t_status();
    t_gate();
    t_full();
    t_flush();
    t_cfg_latch();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog run did not end actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule